// File: doc/BRIEF.md
# Programmable Clock Pulse Throttle

This block forwards a free-running source clock to a gated output. It delivers a programmed number of whole clock pulses and then holds the output low. Software drives it through a single-cycle write port that has two registers.

- The control register carries a start bit and a counter-clear bit. Only a 0-to-1 change of the start bit launches or resumes delivery, so each run takes two writes: a prime write with the start bit at 0, then an assert write with the start bit at 1.
- The count register holds the pulse limit. A new limit is taken up only when a fresh run begins.

An active-low trigger input from surrounding logic can freeze delivery part-way through a run. The pulses already delivered are kept, and software resumes the run with another prime and assert pair. The current state and the number of pulses delivered so far can be read at all times on two status outputs.

Top module: `thr_throttle`

## Requirements
- R1: After reset the state output reads IDLE, the pulse count reads 0 and the gated clock is low.
- R2: The register map has two addresses:
  - Address 0 is the control register. Bit 0 is the start bit and bit 1 is the counter-clear bit; bits 31:2 are ignored.
  - Address 1 is the count register, with the limit in bits 15:0.
  - A run begins only when a control write moves the stored start bit from 0 to 1. A prime write of 0x4 followed by an assert write of 0x5 is the usual sequence.
  - Writing 1 while the start bit already holds 1 changes nothing.
  - A start edge that arrives while the block is running is ignored.
- R3: A start from IDLE or DONE with a limit of N greater than 0 delivers exactly N gated pulses, then enters DONE with the output held low.
- R4: Driving the trigger low during a run stops the output and enters HALT. The delivered count is kept and stays frozen.
- R5: Releasing the trigger does not end HALT. HALT ends only with a start edge (prime, then assert), after which delivery continues until the total reaches N.
- R6: A restart attempted while the trigger is still low delivers no pulses, and the block returns to HALT.
- R7: A control write with bit 1 set returns the block to IDLE, clears the pulse count and stops the output. This wins over a start edge in the same write.
- R8: Every gated pulse has a full-length high phase, equal to the source high phase. Every low gap between pulses is at least one source low phase.
- R9: DONE persists until a new start edge. That start edge reloads the pulse count from zero.
- R10: A limit of 0 delivers no pulses, and the start edge moves the block straight to DONE.
- R11: The state output is encoded as 0 for IDLE, 1 for RUN, 2 for HALT and 3 for DONE. The count output gives the number of pulses delivered in the current run.
- R12: A write to the count register during a run does not change that run. It takes effect at the next start from IDLE or DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 control, 1 count |
| wr_data | input | 32 | Write data |
| trig_n | input | 1 | Active-low halt trigger |
| gclk | output | 1 | Gated output clock |
| state_o | output | 2 | Current state code |
| pulses_o | output | 16 | Pulses delivered in the current run |

## Verification
The bench builds the block with its default widths: a 32-bit write port and a 16-bit counter. With these values, a full 592-pulse run fits well inside the run time, and so do limits of 0 and 1. Random limits up to 300 exercise halts that land at many different points in a run, and the high and low phase widths of every gated pulse are measured against the source clock.

// File: rtl/thr_pkg.sv
`timescale 1ns/1ps
package thr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_DONE = 2'd3
  } thr_state_e;

  localparam logic ADDR_CTRL  = 1'b0;
  localparam logic ADDR_LIMIT = 1'b1;
  localparam int   BIT_START  = 0;
  localparam int   BIT_CLEAR  = 1;
endpackage

// File: rtl/thr_regs.sv
`timescale 1ns/1ps
module thr_regs #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              start_rise,
  output logic              cnt_clr,
  output logic [CNT_W-1:0]  limit_reg
);
  import thr_pkg::*;

  logic start_q;
  logic ctrl_wr;
  logic lim_wr;
  logic unused_hi;

  assign ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
  assign lim_wr     = wr_en && (wr_addr == ADDR_LIMIT);
  assign start_rise = ctrl_wr && wr_data[BIT_START] && !start_q;
  assign cnt_clr    = ctrl_wr && wr_data[BIT_CLEAR];
  assign unused_hi  = ^wr_data[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      limit_reg <= '0;
    end else begin
      if (ctrl_wr) start_q <= wr_data[BIT_START];
      if (lim_wr)  limit_reg <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/thr_fsm.sv
`timescale 1ns/1ps
module thr_fsm #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_rise,
  input  logic                 cnt_clr,
  input  logic                 trig_n,
  input  logic                 pulse_tick,
  input  logic [CNT_W-1:0]     limit_reg,
  output thr_pkg::thr_state_e  state,
  output logic [CNT_W-1:0]     pulses,
  output logic [CNT_W-1:0]     lim_act
);
  import thr_pkg::*;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic t);
    return c + {{(CNT_W-1){1'b0}}, t};
  endfunction

  function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] l);
    return c == l;
  endfunction

  logic [CNT_W-1:0] cnt_nx;
  assign cnt_nx = bump(pulses, pulse_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pulses  <= '0;
      lim_act <= '0;
    end else if (cnt_clr) begin
      state  <= ST_IDLE;
      pulses <= '0;
    end else begin
      pulses <= cnt_nx;
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start_rise) begin
            pulses  <= '0;
            lim_act <= limit_reg;
            state   <= (limit_reg == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (reached(cnt_nx, lim_act)) state <= ST_DONE;
          else if (!trig_n)             state <= ST_HALT;
        end
        ST_HALT: begin
          if (start_rise) state <= ST_RUN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thr_gate.sv
`timescale 1ns/1ps
module thr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_ok,
  output logic gate_en,
  output logic gclk
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_en <= 1'b0;
    else        gate_en <= run_ok;
  end

  assign gclk = clk & gate_en;
endmodule

// File: rtl/thr_throttle.sv
`timescale 1ns/1ps
module thr_throttle #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trig_n,
  output logic              gclk,
  output logic [1:0]        state_o,
  output logic [CNT_W-1:0]  pulses_o
);
  import thr_pkg::*;

  logic             start_rise;
  logic             cnt_clr;
  logic [CNT_W-1:0] limit_reg;
  logic [CNT_W-1:0] lim_act;
  logic [CNT_W-1:0] pulses;
  logic             gate_en;
  logic             run_ok;
  thr_state_e       state;

  thr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start_rise(start_rise), .cnt_clr(cnt_clr),
    .limit_reg(limit_reg)
  );

  thr_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .cnt_clr(cnt_clr),
    .trig_n(trig_n), .pulse_tick(gate_en), .limit_reg(limit_reg),
    .state(state), .pulses(pulses), .lim_act(lim_act)
  );

  assign run_ok = (state == ST_RUN) && trig_n;

  thr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .gate_en(gate_en), .gclk(gclk)
  );

  assign state_o  = state;
  assign pulses_o = pulses;
endmodule

// File: rtl/thr_checker.sv
`timescale 1ns/1ps
module thr_checker #(
  parameter int CNT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_rise,
  input logic                cnt_clr,
  input logic                gate_en,
  input thr_pkg::thr_state_e state,
  input logic [CNT_W-1:0]    pulses,
  input logic [CNT_W-1:0]    lim_act,
  input logic [CNT_W-1:0]    limit_reg
);
  import thr_pkg::*;

  assert_gate_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> state == ST_RUN);

  assert_clear_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (state == ST_IDLE && pulses == '0));

  assert_halt_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !cnt_clr) |=> $stable(pulses));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !start_rise && !cnt_clr) |=> state == ST_DONE);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> pulses <= lim_act);

  assert_zero_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && !cnt_clr && (state == ST_IDLE || state == ST_DONE) && limit_reg == '0)
      |=> (state == ST_DONE && pulses == '0));

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && !cnt_clr && (state == ST_IDLE || state == ST_DONE) && limit_reg != '0)
      |=> (state == ST_RUN && pulses == '0));
endmodule

bind thr_throttle thr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .cnt_clr(cnt_clr),
  .gate_en(gate_en), .state(state), .pulses(pulses), .lim_act(lim_act),
  .limit_reg(limit_reg)
);

// File: tb/sim_thr_throttle.sv
`timescale 1ns/1ps
module sim_thr_throttle;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        trig_n = 1'b1;
  logic        gclk;
  logic [1:0]  state_o;
  logic [15:0] pulses_o;

  int nchk = 0;
  int nfail = 0;
  int gtotal = 0;
  int wbad = 0;
  bit finished = 0;
  realtime t_rise = 0.0;
  realtime t_fall = -100.0;

  always #4 clk = ~clk;

  thr_throttle u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_n(trig_n), .gclk(gclk),
    .state_o(state_o), .pulses_o(pulses_o)
  );

  always @(posedge gclk) begin
    gtotal = gtotal + 1;
    if ($realtime - t_fall < 4.0) wbad = wbad + 1;
    t_rise = $realtime;
  end

  always @(negedge gclk) begin
    if ($realtime - t_rise != 4.0) wbad = wbad + 1;
    t_fall = $realtime;
  end

  function automatic int exp_total(int lim);
    return (lim < 0) ? 0 : lim;
  endfunction

  function automatic int exp_final_state(int lim);
    return 3;
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic go();
    wr(1'b0, 32'h4);
    wr(1'b0, 32'h5);
  endtask

  task automatic full_run(int n, string req);
    int base;
    wr(1'b1, n);
    base = gtotal;
    go();
    tick(n + 4);
    chk(req, state_o, exp_final_state(n));
    chk(req, pulses_o, exp_total(n));
    chk(req, gtotal - base, exp_total(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int base;
    int ph;
    int g0;
    void'($urandom(32'd20240611));
    tick(3);
    chk("R1 state", state_o, 0);
    chk("R1 pulses", pulses_o, 0);
    chk("R1 gclk", gclk, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R11 idle", state_o, 0);

    full_run(592, "R3 592");
    full_run(1, "R3 one");

    // R2: writing 1 again while bit already 1 does nothing
    g0 = gtotal;
    wr(1'b0, 32'h5);
    tick(5);
    chk("R2 rewrite state", state_o, 3);
    chk("R2 rewrite pulses", pulses_o, 1);
    chk("R2 rewrite gclk", gtotal - g0, 0);

    // R9: new start reloads from zero
    wr(1'b1, 20);
    wr(1'b0, 32'h4);
    wr(1'b0, 32'h5);
    chk("R9 reload pulses", pulses_o, 0);
    chk("R9 reload state", state_o, 1);
    tick(25);
    chk("R9 done", pulses_o, 20);

    full_run(0, "R10 zero");

    // R2: start edge during RUN ignored
    wr(1'b1, 60);
    base = gtotal;
    go();
    tick(10);
    wr(1'b0, 32'h4);
    wr(1'b0, 32'h5);
    chk("R2 no restart", (pulses_o > 5) ? 1 : 0, 1);
    tick(60);
    chk("R2 run total", gtotal - base, 60);

    // R12: limit write mid-run deferred
    wr(1'b1, 40);
    base = gtotal;
    go();
    tick(5);
    wr(1'b1, 10);
    tick(45);
    chk("R12 old limit", pulses_o, 40);
    chk("R12 old limit gclk", gtotal - base, 40);
    full_run(10, "R12 new limit");

    // R4 / R5: halt and resume
    wr(1'b1, 50);
    base = gtotal;
    go();
    tick(10);
    trig_n = 1'b0;
    tick(3);
    chk("R4 halt state", state_o, 2);
    ph = pulses_o;
    chk("R4 kept", gtotal - base, ph);
    tick(5);
    chk("R4 frozen", pulses_o, ph);
    chk("R4 frozen gclk", gtotal - base, ph);
    trig_n = 1'b1;
    tick(5);
    chk("R5 release only", state_o, 2);
    chk("R5 release gclk", gtotal - base, ph);
    go();
    tick(60);
    chk("R5 resumed", pulses_o, 50);
    chk("R5 resumed gclk", gtotal - base, 50);

    // R6: restart while trigger low
    wr(1'b1, 30);
    base = gtotal;
    go();
    tick(5);
    trig_n = 1'b0;
    tick(3);
    ph = pulses_o;
    go();
    tick(5);
    chk("R6 still halt", state_o, 2);
    chk("R6 no pulses", gtotal - base, ph);
    trig_n = 1'b1;
    go();
    tick(40);
    chk("R6 completed", gtotal - base, 30);

    // R7: counter clear mid-run, and priority over start
    wr(1'b1, 100);
    go();
    tick(20);
    wr(1'b0, 32'h6);
    g0 = gtotal;
    chk("R7 idle", state_o, 0);
    chk("R7 zero", pulses_o, 0);
    tick(5);
    chk("R7 stopped", gtotal - g0, 0);
    wr(1'b0, 32'h4);
    wr(1'b0, 32'h7);
    g0 = gtotal;
    tick(5);
    chk("R7 priority state", state_o, 0);
    chk("R7 priority gclk", gtotal - g0, 0);

    // random runs, some with a halt
    for (int i = 0; i < 6; i++) begin
      int n;
      int k;
      n = $urandom_range(300, 2);
      k = $urandom_range(n / 2, 1);
      wr(1'b1, n);
      base = gtotal;
      go();
      if ($urandom_range(1, 0) == 1) begin
        tick(k);
        trig_n = 1'b0;
        tick(3);
        chk("R4 random halt", state_o, 2);
        trig_n = 1'b1;
        go();
      end
      tick(n + 4);
      chk("R3 random total", gtotal - base, exp_total(n));
      chk("R11 random done", state_o, exp_final_state(n));
    end

    chk("R8 phase widths", wbad, 0);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule